// File: doc/BRIEF.md
# SPI Register-Read Burst Controller

This block is an SPI controller that performs one complete register-read transaction against a single peripheral each time it is started. A host presents a 7-bit register address and a byte count, and pulses `start`. The controller lowers chip select and shifts out a command byte, which is the address with its top bit set to mark a read. It then shifts out filler bytes of zero while it clocks in the requested number of reply bytes. Chip select is held low for the whole burst.

Every byte on the wire is a full-duplex exchange. The byte that comes back while the command is going out carries no data and is dropped. Each byte after it is handed to the host on `rx_data`, together with a one-cycle `rx_valid` strobe. Clock polarity and clock phase are sampled at `start`, so any of the four SPI modes can be chosen per transaction. The serial clock comes from the system clock through a parameterised half-period divider.

Top module: `spi_rd_master`

## Requirements
- R1: `cs_n` is low in every cycle in which `busy` is high. It goes low one cycle after an accepted `start`, at least HALF_DIV system clocks before the first SCLK edge. It falls exactly once per transaction and does not rise between bytes.
- R2: The first byte on `mosi` is `{1'b1, reg_addr[6:0]}`, sent most significant bit first.
- R3: After the command byte, exactly `byte_count` filler bytes of 0x00 go out on `mosi`, giving `byte_count`+1 bytes in total per transaction.
- R4: The byte received during the command byte is never reported. Each later received byte is assembled MSB first and presented on `rx_data`, with `rx_valid` high for exactly one system clock, in the order received.
- R5: While idle, `sclk` equals `cpol` as registered one cycle earlier. Each byte spends 16 SCLK edges, so `sclk` is back at its idle level when chip select is released.
- R6: With phase 0, both sides sample on the first edge of each bit, and `mosi` holds the bit before that edge. With phase 1, `mosi` changes on the first edge and both sides sample on the second edge. The sampling edge is therefore rising in modes 0 and 3 and falling in modes 1 and 2.
- R7: Each SCLK half-period lasts HALF_DIV system clocks. The default of 5 gives 10 MHz from a 100 MHz system clock.
- R8: A byte count of 0 sends only the command byte, produces no `rx_valid`, and still ends with `done`.
- R9: A `start` pulse while `busy` is high has no effect: the address, count and mode of the running transaction are kept, and no further transaction follows.
- R10: `done` is high for one system clock, in the cycle where `cs_n` returns high and `busy` returns low.
- R11: In reset, `cs_n` is high and `busy`, `rx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a transaction when idle |
| reg_addr | input | 7 | Register address to read |
| byte_count | input | 8 | Number of data bytes to return |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| busy | output | 1 | A transaction is in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The bench builds the block with its defaults: HALF_DIV of 5, a 7-bit address and an 8-bit count. Together with the 10 ns bench clock, this puts the 10 MHz serial clock ratio under direct measurement. With short half-periods, bursts of up to several bytes in all four modes complete within a few thousand cycles. This also brings the zero-count case and a start that arrives mid-burst within reach. A mode-aware peripheral model answers on MISO and records what arrives on MOSI. This checks the command byte, the filler bytes and the single chip-select fall as well as the returned data.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int BYTE_W = 8;
    localparam int EDGES_PER_BYTE = 2 * BYTE_W;
    localparam int EIDX_W = $clog2(EDGES_PER_BYTE);
    localparam logic [BYTE_W-1:0] FILL_BYTE = '0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic load_cmd;
        logic load_fill;
        logic shift;
        logic sample;
        logic deliver;
    } shift_ctl_t;

    function automatic logic [BYTE_W-1:0] read_cmd(input logic [BYTE_W-2:0] addr);
        return {1'b1, addr};
    endfunction

endpackage

// File: rtl/spi_rd_clkgen.sv
module spi_rd_clkgen #(
    parameter int HALF_DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int TMR_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HALF_DIV - 1);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tmr <= '0;
        end else if (tmr == TMR_LAST) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assign tick = en && (tmr == TMR_LAST);

endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter
    import spi_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              miso,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] rx_next;

    assign rx_next = {rx_sr[BYTE_W-2:0], miso};
    assign mosi    = tx_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (ctl.load_cmd) begin
            tx_sr <= cmd;
        end else if (ctl.load_fill) begin
            tx_sr <= FILL_BYTE;
        end else if (ctl.shift) begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (ctl.sample) begin
                rx_sr <= rx_next;
            end
            if (ctl.deliver) begin
                rx_data <= rx_next;
            end
            rx_valid <= ctl.deliver;
        end
    end

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             tick,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             done,
    output shift_ctl_t       ctl
);
    localparam logic [EIDX_W-1:0] EIDX_LAST = EIDX_W'(EDGES_PER_BYTE - 1);
    localparam logic [EIDX_W-2:0] BIT_LAST  = (EIDX_W-1)'(BYTE_W - 1);

    xfer_state_e      state;
    logic [EIDX_W-1:0] eidx;
    logic [CNT_W-1:0] byte_idx;
    logic [CNT_W-1:0] count_q;
    logic             cpol_q;
    logic             cpha_q;

    logic accept;
    logic edge_now;
    logic samp_edge;
    logic first_byte;
    logic byte_end;
    logic last_byte;

    assign accept     = (state == ST_IDLE) && start;
    assign edge_now   = (state == ST_SHIFT) && tick;
    assign samp_edge  = (eidx[0] == cpha_q);
    assign first_byte = (byte_idx == '0);
    assign byte_end   = (eidx == EIDX_LAST);
    assign last_byte  = (byte_idx == count_q);
    assign busy       = (state != ST_IDLE);

    always_comb begin
        ctl           = '0;
        ctl.load_cmd  = accept;
        ctl.sample    = edge_now && samp_edge;
        ctl.deliver   = edge_now && samp_edge && (eidx[EIDX_W-1:1] == BIT_LAST) && !first_byte;
        if (edge_now && !samp_edge) begin
            if (cpha_q) begin
                ctl.load_fill = (eidx == '0) && !first_byte;
                ctl.shift     = (eidx != '0);
            end else begin
                ctl.load_fill = byte_end;
                ctl.shift     = !byte_end;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            eidx     <= '0;
            byte_idx <= '0;
            count_q  <= '0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            cs_n     <= 1'b1;
            sclk     <= cpol;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk <= cpol;
                    cs_n <= 1'b1;
                    if (start) begin
                        state    <= ST_SHIFT;
                        eidx     <= '0;
                        byte_idx <= '0;
                        count_q  <= byte_count;
                        cpol_q   <= cpol;
                        cpha_q   <= cpha;
                        cs_n     <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        eidx <= eidx + 1'b1;
                        if (byte_end) begin
                            byte_idx <= byte_idx + 1'b1;
                            if (last_byte) begin
                                state <= ST_TRAIL;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    sclk <= cpol_q;
                    if (tick) begin
                        state <= ST_IDLE;
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cs_n  <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_rd_master.sv
module spi_rd_master
    import spi_rd_pkg::*;
#(
    parameter int HALF_DIV = 5,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [6:0]       reg_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             cpol,
    input  logic             cpha,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             done
);
    shift_ctl_t ctl;
    logic       tick;
    logic       busy_i;

    assign busy = busy_i;

    spi_rd_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .en   (busy_i),
        .tick (tick)
    );

    spi_rd_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_count (byte_count),
        .cpol       (cpol),
        .cpha       (cpha),
        .tick       (tick),
        .busy       (busy_i),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .done       (done),
        .ctl        (ctl)
    );

    spi_rd_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cmd      (read_cmd(reg_addr)),
        .miso     (miso),
        .mosi     (mosi),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic cpol,
    input logic rx_valid,
    input logic done
);
    AST_SELECT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cs_n); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R4

    AST_VALID_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> busy); // R4

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (sclk == $past(cpol))); // R5

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy)); // R10

    AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done); // R10

endmodule

bind spi_rd_master spi_rd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .cpol     (cpol),
    .rx_valid (rx_valid),
    .done     (done)
);

// File: tb/sim_spi_rd_master.sv
module sim_spi_rd_master;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] cnt = '0;
    logic       m_cpol = 1'b0;
    logic       m_cpha = 1'b0;
    logic       miso_r = 1'b0;
    logic       busy, cs_n, sclk, mosi, rx_valid, done;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0;
    int mon_chk = 0, mon_err = 0;

    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rd_master #(.HALF_DIV(HALF), .CNT_W(8)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .reg_addr   (addr),
        .byte_count (cnt),
        .cpol       (m_cpol),
        .cpha       (m_cpha),
        .busy       (busy),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso_r),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .done       (done)
    );

    // Peripheral model: mode-aware, replies from s_tx, records MOSI into s_rx
    logic [7:0] s_tx[0:63];
    logic [7:0] s_rx[0:63];
    logic [7:0] s_acc = '0;
    int s_dptr = 0, s_sbits = 0, s_rxn = 0, s_falls = 0;
    logic s_cs_prev = 1'b1, s_sclk_prev = 1'b0;

    function automatic logic s_bit(input int k);
        if (k >= 512) return 1'b0;
        return s_tx[k/8][7 - (k%8)];
    endfunction

    always @(sclk or cs_n) begin
        if (s_cs_prev === 1'b1 && cs_n === 1'b0) begin
            s_falls = s_falls + 1;
            s_sbits = 0;
            s_rxn   = 0;
            s_dptr  = 0;
            if (!m_cpha) begin
                miso_r = s_bit(0);
                s_dptr = 1;
            end
        end else if (cs_n === 1'b0 && sclk !== s_sclk_prev) begin
            if ((sclk != m_cpol) != m_cpha) begin
                s_acc   = {s_acc[6:0], mosi};
                s_sbits = s_sbits + 1;
                if (s_sbits % 8 == 0) begin
                    s_rx[s_rxn] = s_acc;
                    s_rxn = s_rxn + 1;
                end
            end else begin
                miso_r = s_bit(s_dptr);
                s_dptr = s_dptr + 1;
            end
        end
        s_cs_prev   = cs_n;
        s_sclk_prev = sclk;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            mon_chk = mon_chk + 1;
            if (exp_q.size() == 0) begin
                mon_err = mon_err + 1;
                $display("FAIL R4 R8: unexpected rx_valid, actual %0h expected none", rx_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rx_data !== e) begin
                    mon_err = mon_err + 1;
                    $display("FAIL R4 R6: rx_data actual %0h expected %0h", rx_data, e);
                end
            end
        end
    end

    // SCLK half-period measurement (R7)
    int p_cnt = 0, p_min = 1000, p_max = 0;
    bit p_seen = 1'b0;
    logic p_last = 1'b0;
    always @(negedge clk) begin
        if (cs_n !== 1'b0) begin
            p_cnt  = 0;
            p_seen = 1'b0;
        end else begin
            p_cnt = p_cnt + 1;
            if (sclk !== p_last) begin
                if (p_seen) begin
                    if (p_cnt < p_min) p_min = p_cnt;
                    if (p_cnt > p_max) p_max = p_cnt;
                end
                p_seen = 1'b1;
                p_cnt  = 0;
            end
        end
        p_last = sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'((seed * 73 + i * 29 + 17) & 255);
    endfunction

    task automatic xfer(input logic [6:0] a, input int n, input bit p, input bit h,
                        input int seed, input bit poke);
        int falls0;
        bit fill_ok;
        m_cpol = p;
        m_cpha = h;
        s_tx[0] = 8'hE7;
        for (int i = 0; i < n; i++) begin
            s_tx[i+1] = dat(seed, i);
            exp_q.push_back(dat(seed, i));
        end
        for (int i = n + 1; i < 64; i++) s_tx[i] = 8'hFF;
        repeat (3) @(negedge clk);
        falls0 = s_falls;
        addr  = a;
        cnt   = n[7:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        addr  = ~a;
        if (poke) begin
            repeat (30) @(negedge clk);
            addr  = 7'h55;
            cnt   = 8'd2;
            m_cpol = ~p;
            m_cpha = ~h;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            m_cpol = p;
            m_cpha = h;
        end
        while (done !== 1'b1) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R10 release with done", {cs_n, busy}, 2'b10);
        @(negedge clk);
        check(done === 1'b0, "R10 done width", done, 0);
        check(sclk === p, "R5 idle level", sclk, p);
        check(s_rxn == n + 1, "R3 byte count on mosi", s_rxn, n + 1);
        check(s_rx[0] === {1'b1, a}, "R2 command byte", s_rx[0], {1'b1, a});
        fill_ok = 1'b1;
        for (int i = 1; i <= n; i++) if (s_rx[i] !== 8'h00) fill_ok = 1'b0;
        check(fill_ok, "R3 filler bytes", fill_ok, 1);
        check(s_falls - falls0 == 1, "R1 single select", s_falls - falls0, 1);
        if (n == 0) check(exp_q.size() == 0, "R8 no data", exp_q.size(), 0);
        else        check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            check(busy === 1'b0 && s_falls - falls0 == 1, "R9 start ignored", s_falls - falls0, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_err + mon_err + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0 && rx_valid === 1'b0 && done === 1'b0,
              "R11 reset state", {cs_n, busy, rx_valid, done}, 4'b1000);
        check(sclk === m_cpol, "R5 idle after reset", sclk, m_cpol);

        xfer(7'h75, 3, 1'b0, 1'b0, 1, 1'b0); // mode 0, R6
        xfer(7'h12, 4, 1'b0, 1'b1, 2, 1'b0); // mode 1, R6
        xfer(7'h00, 2, 1'b1, 1'b0, 3, 1'b0); // mode 2, R6
        xfer(7'h7F, 5, 1'b1, 1'b1, 4, 1'b0); // mode 3, R6
        xfer(7'h2A, 0, 1'b0, 1'b0, 5, 1'b0); // R8
        xfer(7'h3C, 6, 1'b1, 1'b1, 6, 1'b1); // R9
        xfer(7'h41, 1, 1'b0, 1'b1, 7, 1'b0);

        check(p_min == HALF && p_max == HALF, "R7 half period", p_max, HALF);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end

endmodule